// File: doc/BRIEF.md
# Direction-Reversing 4x4 Keypad Scanner

This block reads a sixteen-key matrix over eight shared lines. Lines 3:0 carry the four rows and lines 7:4 carry the four columns. The block never drives a line high. A line is either actively pulled to 0, when its output enable is set, or left floating, in which case an external weak pull-up reads it as 1. Every line input first passes through a two-flop synchronizer.

While idle, the scanner drives the columns low and watches the rows for a 0. When a press appears, it waits out contact bounce and captures the row pattern. It then reverses the line directions, driving the rows low and letting the columns float. After a settling wait it captures the column pattern. The two nibbles form an 8-bit keycode. A keycode that names a single key is converted to a 4-bit value and reported with a one-cycle strobe. The scanner then waits until the columns read all ones, waits out bounce again, restores the idle direction, waits for the lines to settle, and resumes watching.

Top module: `kp_rc_scanner`

## Requirements
- R1: After reset, `line_oe` is 8'hF0 (columns driven low, rows floating), `key_valid` is 0, `key_code` is 8'hFF and `key_value` is 0.
- R2: In the idle phase, `line_oe` stays 8'hF0 for as long as the synchronized rows read 4'b1111, and no strobe is produced.
- R3: A 0 on any synchronized row starts a press debounce of DEBOUNCE_CYC cycles, with `line_oe` still 8'hF0. The row nibble is captured at the end of that debounce.
- R4: After the row capture, `line_oe` becomes 8'h0F (rows driven low, columns floating) for SETTLE_CYC cycles, and then the synchronized column nibble is captured.
- R5: The keycode is {captured columns, captured rows}: bit 7 is column 0, bit 4 is column 3, and bit r is row r.
- R6: A valid code maps to a key value by a phone-style layout. Rows 0, 1 and 2 with columns 0, 1 and 2 give 1-9 in row-major order. Row 3 with columns 0, 1 and 2 gives E, 0 and F. Column 3 with rows 0 to 3 gives A to D. Examples: 0xB7 maps to 0, 0x7E to 1, 0xBE to 2, 0xDE to 3 and 0x7D to 4.
- R7: A valid code raises `key_valid` for exactly one cycle, the cycle after column capture plus one evaluation cycle. `key_code` and `key_value` present the new key in that cycle and hold it afterwards.
- R8: A code without exactly one 0 in each nibble produces no strobe and leaves `key_code` and `key_value` unchanged. The scanner still proceeds to wait for release.
- R9: After evaluation, `line_oe` stays 8'h0F until the synchronized columns read 4'b1111. A release debounce of DEBOUNCE_CYC cycles then follows. `line_oe` then returns to 8'hF0 for SETTLE_CYC cycles before rows are watched again. Further presses in this span cause no strobe.
- R10: Line inputs reach the controller only through a two-flop synchronizer, so a change on `line_in` is acted on two cycles after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 8 | Raw line levels; 7:4 columns, 3:0 rows |
| line_oe | output | 8 | Per-line enable to drive the line to 0 |
| key_valid | output | 1 | One-cycle strobe for a decoded key |
| key_code | output | 8 | Last valid keycode {columns, rows} |
| key_value | output | 4 | Last valid key value |

## Verification
The hardest states to reach from the ports are the ones where the press pattern changes between the two phases. Examples are a press that vanishes during the debounce, a second key that appears in the same row only after the rows were captured, and a new key pressed while the scanner is still waiting for release. The bench holds a switch-matrix model of the keypad that computes each line from the current enables and the set of closed switches. It opens and closes switches at chosen cycle offsets relative to those phases. A behavioural model, running on every clock, predicts the enables, the strobe and the reported key for each of these cases.

// File: rtl/kp_pkg.sv
package kp_pkg;

  typedef enum logic [2:0] {
    PH_ARM   = 3'd0,
    PH_IDLE  = 3'd1,
    PH_PDEB  = 3'd2,
    PH_CSET  = 3'd3,
    PH_EVAL  = 3'd4,
    PH_WREL  = 3'd5,
    PH_RDEB  = 3'd6
  } kp_phase_e;

  function automatic logic kp_one_low(input logic [3:0] nib);
    return ($countones(~nib) == 1);
  endfunction

  function automatic logic kp_code_ok(input logic [7:0] code);
    return kp_one_low(code[7:4]) && kp_one_low(code[3:0]);
  endfunction

  function automatic logic [1:0] kp_low_pos(input logic [3:0] nib);
    logic [1:0] p;
    p = 2'd0;
    for (int i = 0; i < 4; i++)
      if (!nib[i]) p = 2'(i);
    return p;
  endfunction

  // column index counts from bit 7 downward, row index from bit 0 upward
  function automatic logic [3:0] kp_code_value(input logic [7:0] code);
    logic [1:0] r;
    logic [1:0] c;
    logic [3:0] v;
    r = kp_low_pos(code[3:0]);
    c = 2'd3 - kp_low_pos(code[7:4]);
    if (c == 2'd3)
      v = 4'hA + {2'b00, r};
    else if (r == 2'd3)
      v = (c == 2'd0) ? 4'hE : ((c == 2'd1) ? 4'h0 : 4'hF);
    else
      v = 4'(r * 3 + c + 1);
    return v;
  endfunction

endpackage

// File: rtl/kp_sync.sv
module kp_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stg
      always_ff @(posedge clk) begin
        if (!rst_n) stg[s] <= '1;
        else if (s == 0) stg[s] <= d_in;
        else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign d_out = stg[STAGES-1];
endmodule

// File: rtl/kp_delay.sv
module kp_delay #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic [CW-1:0] rst_val,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= rst_val;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/kp_scan_fsm.sv
module kp_scan_fsm
  import kp_pkg::*;
#(
  parameter int SETTLE_CYC   = 8000,
  parameter int DEBOUNCE_CYC = 4000000,
  localparam int MAXC = (SETTLE_CYC > DEBOUNCE_CYC) ? SETTLE_CYC : DEBOUNCE_CYC,
  localparam int CW   = $clog2(MAXC + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] lines_s,
  output logic [7:0] line_oe,
  output logic       key_valid,
  output logic [7:0] key_code,
  output logic [3:0] key_value,
  output logic       ev_press,
  output logic       ev_eval,
  output logic       ev_release
);
  localparam logic [CW-1:0] SET_LD = CW'(SETTLE_CYC - 1);
  localparam logic [CW-1:0] DEB_LD = CW'(DEBOUNCE_CYC - 1);

  kp_phase_e ph, ph_nx;
  logic          t_load;
  logic [CW-1:0] t_val;
  logic          t_done;
  logic [3:0]    row_q, col_q;
  logic [7:0]    code_w;

  kp_delay #(.CW(CW)) u_delay (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val),
    .rst_val(SET_LD), .expired(t_done)
  );

  assign code_w     = {col_q, row_q};
  assign ev_press   = (ph == PH_IDLE) && (lines_s[3:0] != 4'hF);
  assign ev_eval    = (ph == PH_EVAL);
  assign ev_release = (ph == PH_WREL) && (lines_s[7:4] == 4'hF);

  always_comb begin
    ph_nx  = ph;
    t_load = 1'b0;
    t_val  = SET_LD;
    unique case (ph)
      PH_ARM:  if (t_done) ph_nx = PH_IDLE;
      PH_IDLE: if (ev_press) begin ph_nx = PH_PDEB; t_load = 1'b1; t_val = DEB_LD; end
      PH_PDEB: if (t_done) begin ph_nx = PH_CSET; t_load = 1'b1; t_val = SET_LD; end
      PH_CSET: if (t_done) ph_nx = PH_EVAL;
      PH_EVAL: ph_nx = PH_WREL;
      PH_WREL: if (ev_release) begin ph_nx = PH_RDEB; t_load = 1'b1; t_val = DEB_LD; end
      PH_RDEB: if (t_done) begin ph_nx = PH_ARM; t_load = 1'b1; t_val = SET_LD; end
      default: ph_nx = PH_ARM;
    endcase
  end

  always_comb begin
    unique case (ph)
      PH_CSET, PH_EVAL, PH_WREL, PH_RDEB: line_oe = 8'h0F;
      default:                             line_oe = 8'hF0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph        <= PH_ARM;
      row_q     <= 4'hF;
      col_q     <= 4'hF;
      key_valid <= 1'b0;
      key_code  <= 8'hFF;
      key_value <= 4'h0;
    end else begin
      ph        <= ph_nx;
      key_valid <= 1'b0;
      if (ph == PH_PDEB && t_done) row_q <= lines_s[3:0];
      if (ph == PH_CSET && t_done) col_q <= lines_s[7:4];
      if (ev_eval && kp_code_ok(code_w)) begin
        key_valid <= 1'b1;
        key_code  <= code_w;
        key_value <= kp_code_value(code_w);
      end
    end
  end
endmodule

// File: rtl/kp_rc_scanner.sv
module kp_rc_scanner #(
  parameter int SETTLE_CYC   = 8000,
  parameter int DEBOUNCE_CYC = 4000000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] line_in,
  output logic [7:0] line_oe,
  output logic       key_valid,
  output logic [7:0] key_code,
  output logic [3:0] key_value
);
  logic [7:0] lines_s;
  logic       ev_press, ev_eval, ev_release;

  kp_sync #(.WIDTH(8), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(line_in), .d_out(lines_s)
  );

  kp_scan_fsm #(.SETTLE_CYC(SETTLE_CYC), .DEBOUNCE_CYC(DEBOUNCE_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .lines_s(lines_s), .line_oe(line_oe),
    .key_valid(key_valid), .key_code(key_code), .key_value(key_value),
    .ev_press(ev_press), .ev_eval(ev_eval), .ev_release(ev_release)
  );
endmodule

// File: rtl/kp_rc_scanner_chk.sv
module kp_rc_scanner_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] line_oe,
  input logic       key_valid,
  input logic [7:0] key_code,
  input logic [3:0] key_value,
  input logic       ev_press,
  input logic       ev_eval,
  input logic       ev_release
);
  function automatic logic [7:0] val2code(input logic [3:0] v);
    logic [1:0] r, c;
    if (v >= 4'hA && v <= 4'hD) begin r = 2'(v - 4'hA); c = 2'd3; end
    else if (v == 4'hE) begin r = 2'd3; c = 2'd0; end
    else if (v == 4'h0) begin r = 2'd3; c = 2'd1; end
    else if (v == 4'hF) begin r = 2'd3; c = 2'd2; end
    else begin r = 2'((v - 1) / 3); c = 2'((v - 1) % 3); end
    return {~(4'b1000 >> c), ~(4'b0001 << r)};
  endfunction

  AST_OE_HALVES: assert property (@(posedge clk) disable iff (!rst_n)
    (line_oe == 8'hF0) || (line_oe == 8'h0F)); // R4
  AST_PRESS_IN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_press |-> line_oe == 8'hF0); // R3
  AST_PRESS_KEEPS_COLS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_press |=> line_oe == 8'hF0); // R3
  AST_RELEASE_IN_REV: assert property (@(posedge clk) disable iff (!rst_n)
    ev_release |-> line_oe == 8'h0F); // R9
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> !key_valid); // R7
  AST_STROBE_AFTER_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
    ev_eval |=> (key_valid == ($countones(~key_code[7:4]) == 1 &&
                                $countones(~key_code[3:0]) == 1 &&
                                $changed(key_code) || key_valid))); // R8
  AST_STROBE_CODE_OK: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> ($countones(~key_code[7:4]) == 1) &&
                  ($countones(~key_code[3:0]) == 1)); // R8
  AST_VALUE_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> key_code == val2code(key_value)); // R6
  AST_STROBE_REVERSED: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> line_oe == 8'h0F); // R7
  AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    !key_valid && !$past(ev_eval) |-> $stable(key_code) && $stable(key_value)); // R8
endmodule

bind kp_rc_scanner kp_rc_scanner_chk u_chk (
  .clk(clk), .rst_n(rst_n), .line_oe(line_oe), .key_valid(key_valid),
  .key_code(key_code), .key_value(key_value),
  .ev_press(ev_press), .ev_eval(ev_eval), .ev_release(ev_release)
);

// File: tb/kp_rc_scanner_tb.sv
module kp_rc_scanner_tb_top;
  localparam int SET = 4;
  localparam int DEB = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] line_in;
  logic [7:0] line_oe;
  logic       key_valid;
  logic [7:0] key_code;
  logic [3:0] key_value;
  logic [15:0] closed = '0;   // index r*4 + (column bit - 4)

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int strobes = 0;
  logic [3:0] last_val;

  always #5 clk = ~clk;

  kp_rc_scanner #(.SETTLE_CYC(SET), .DEBOUNCE_CYC(DEB)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .line_oe(line_oe),
    .key_valid(key_valid), .key_code(key_code), .key_value(key_value)
  );

  // switch matrix with pull-ups: a line is low when driven or bridged to a driven line
  always_comb begin
    line_in = 8'hFF;
    for (int r = 0; r < 4; r++) begin
      if (line_oe[r]) line_in[r] = 1'b0;
      for (int b = 0; b < 4; b++)
        if (closed[r*4+b] && line_oe[4+b]) line_in[r] = 1'b0;
    end
    for (int b = 0; b < 4; b++) begin
      if (line_oe[4+b]) line_in[4+b] = 1'b0;
      for (int r = 0; r < 4; r++)
        if (closed[r*4+b] && line_oe[r]) line_in[4+b] = 1'b0;
    end
  end

  function automatic logic [7:0] key_to_code(input int k);
    case (k)
      0: return 8'hB7;  1: return 8'h7E;  2: return 8'hBE;  3: return 8'hDE;
      4: return 8'h7D;  5: return 8'hBD;  6: return 8'hDD;  7: return 8'h7B;
      8: return 8'hBB;  9: return 8'hDB; 10: return 8'hEE; 11: return 8'hED;
      12: return 8'hEB; 13: return 8'hE7; 14: return 8'h77; default: return 8'hD7;
    endcase
  endfunction

  function automatic int switch_of(input int k);
    logic [7:0] c;
    int r, b;
    c = key_to_code(k);
    r = 0; b = 0;
    for (int i = 0; i < 4; i++) begin
      if (!c[i]) r = i;
      if (!c[4+i]) b = i;
    end
    return r*4 + b;
  endfunction

  // behavioural reference: phase number, cycles spent in phase, two-deep input delay
  int   m_ph, m_t;
  logic [7:0] m_d1, m_d2;
  logic [3:0] m_row, m_col;
  logic       m_kv;
  logic [7:0] m_code;
  logic [3:0] m_val;

  function automatic int zero_count(input logic [3:0] n);
    int z = 0;
    for (int i = 0; i < 4; i++) if (!n[i]) z++;
    return z;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_t = 0; m_d1 = 8'hFF; m_d2 = 8'hFF;
      m_row = 4'hF; m_col = 4'hF; m_kv = 0; m_code = 8'hFF; m_val = 0;
    end else begin
      m_kv = 0;
      case (m_ph)
        0: if (m_t == SET-1) begin m_ph = 1; m_t = 0; end else m_t++;
        1: if (m_d2[3:0] != 4'hF) begin m_ph = 2; m_t = 0; end
        2: if (m_t == DEB-1) begin m_row = m_d2[3:0]; m_ph = 3; m_t = 0; end else m_t++;
        3: if (m_t == SET-1) begin m_col = m_d2[7:4]; m_ph = 4; m_t = 0; end else m_t++;
        4: begin
             if (zero_count(m_row) == 1 && zero_count(m_col) == 1) begin
               m_kv = 1; m_code = {m_col, m_row};
               for (int k = 0; k < 16; k++) if (key_to_code(k) == m_code) m_val = 4'(k);
             end
             m_ph = 5;
           end
        5: if (m_d2[7:4] == 4'hF) begin m_ph = 6; m_t = 0; end
        default: if (m_t == DEB-1) begin m_ph = 0; m_t = 0; end else m_t++;
      endcase
      m_d2 = m_d1; m_d1 = line_in;
    end
  end

  function automatic logic [7:0] m_oe();
    return (m_ph >= 3) ? 8'h0F : 8'hF0;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s cyc=%0d actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(line_oe == m_oe(), "R2/R3/R4/R9 line_oe", line_oe, m_oe());
      chk(key_valid == m_kv, "R7 key_valid", key_valid, m_kv);
      chk(key_code == m_code, "R5 key_code", key_code, m_code);
      chk(key_value == m_val, "R6 key_value", key_value, m_val);
      if (key_valid) begin strobes++; last_val = key_value; end
    end
    if (cyc > 100000) begin
      chk(0, "watchdog", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tap_key(input int k);
    int s0;
    s0 = strobes;
    closed[switch_of(k)] = 1'b1;
    wait_cyc(DEB + SET + 12);
    chk(strobes == s0 + 1, "R7 one strobe per press", strobes - s0, 1);
    chk(last_val == 4'(k), "R6 value of pressed key", last_val, k);
    chk(key_code == key_to_code(k), "R5 code of pressed key", key_code, key_to_code(k));
    closed = '0;
    wait_cyc(DEB + SET + 8);
  endtask

  initial begin
    int s0;
    wait_cyc(3);
    // R1 reset values
    chk(line_oe == 8'hF0, "R1 oe at reset", line_oe, 8'hF0);
    chk(key_valid == 0, "R1 strobe at reset", key_valid, 0);
    chk(key_code == 8'hFF, "R1 code at reset", key_code, 8'hFF);
    rst_n = 1'b1;
    wait_cyc(30);
    chk(strobes == 0 && line_oe == 8'hF0, "R2 idle no press", strobes, 0);
    for (int k = 0; k < 16; k++) tap_key(k);          // R5 R6 R7 R9
    // R8 two keys in one row: column phase sees two zeros
    s0 = strobes;
    closed[switch_of(1)] = 1; closed[switch_of(3)] = 1;
    wait_cyc(DEB + SET + 12);
    chk(strobes == s0, "R8 two keys no strobe", strobes - s0, 0);
    chk(key_value == 4'hF, "R8 value held", key_value, 4'hF);
    closed = '0; wait_cyc(DEB + SET + 8);
    // R8 glitch: press vanishes during debounce (rows read 1111 at capture)
    s0 = strobes;
    closed[switch_of(5)] = 1; wait_cyc(3); closed = '0;
    wait_cyc(DEB + SET + 12);
    chk(strobes == s0, "R8 vanished press", strobes - s0, 0);
    wait_cyc(DEB + SET + 8);
    // R10 one-cycle pulse still reaches controller through synchronizer
    s0 = strobes;
    closed[switch_of(9)] = 1; wait_cyc(1); closed = '0;
    wait_cyc(3 * DEB + 3 * SET + 20);
    chk(strobes == s0, "R10 short pulse no key", strobes - s0, 0);
    // R4 second key appears in same row after row capture, before column capture
    s0 = strobes;
    closed[switch_of(4)] = 1; wait_cyc(DEB + 3);
    closed[switch_of(6)] = 1;
    wait_cyc(SET + 12);
    chk(strobes == s0, "R4 late second key invalid", strobes - s0, 0);
    closed = '0; wait_cyc(DEB + SET + 8);
    // R9 new key while first still held: no strobe until full release
    s0 = strobes;
    closed[switch_of(2)] = 1; wait_cyc(DEB + SET + 12);
    closed[switch_of(8)] = 1; wait_cyc(DEB + 10);
    closed[switch_of(2)] = 0; wait_cyc(DEB + 10);
    chk(strobes == s0 + 1, "R9 no strobe while held", strobes - s0, 1);
    chk(line_oe == 8'h0F, "R9 waiting release", line_oe, 8'h0F);
    closed = '0; wait_cyc(DEB + SET + 8);
    tap_key(7);
    // R3 bouncy press: toggles before settling
    s0 = strobes;
    for (int i = 0; i < 3; i++) begin closed[switch_of(12)] = 1; wait_cyc(2); closed = '0; wait_cyc(1); end
    closed[switch_of(12)] = 1;
    wait_cyc(DEB + SET + 12);
    chk(last_val == 4'hC, "R3 bounce then key C", last_val, 4'hC);
    closed = '0; wait_cyc(DEB + SET + 8);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule